// File: doc/BRIEF.md
# Trap Entry, Cause Selection and Privilege Return Unit

This unit sits beside the retire stage of a simple in-order core. Each cycle it looks at the exception requests raised by the current instruction, the interrupt pending and enable lines, and a privileged-return strobe. It decides whether a trap is taken and which one, and it sends the fetch stage a redirect address in the same cycle. On the clock edge that follows, it records what happened.

A taken trap saves the PC of the affected instruction, saves a code that identifies the source, saves the mode the core was in, and raises the core to machine mode. A legal return sends fetch back to the saved PC and restores the saved mode. A return issued from a mode that is too low is turned into an illegal-instruction trap. Four trap registers can be read and written through a small CSR port: handler vector, exception PC, cause and mode status. Decoding of CSR addresses is left to the core.

Top module: `trap_ctrl`

## Requirements
- R1: After reset the current mode is machine (3) and the saved mode is user (0). The vector, exception-PC and cause registers are zero, and no redirect is requested. Mode encoding: user=0, supervisor=1, machine=3. The value 2 is never held.
- R2: `exc_req[k]` requests exception code k. Only codes 0 to 8, 12, 13 and 15 are recognised; requests on 9, 10, 11 and 14 are ignored. When several recognised requests are present, the lowest code is taken.
- R3: In a trap cycle `redirect_valid` is 1 in that same cycle. On the next edge the exception-PC register takes `exc_pc`, the saved mode takes the current mode, and the current mode becomes machine.
- R4: The cause register holds the code in its low bits. Bit XLEN-1 is 1 for an interrupt and 0 for an exception.
- R5: When vector bits [1:0] are 00, 10 or 11, every trap redirects to the vector with bits [1:0] cleared (the base).
- R6: When vector bits [1:0] are 01, an interrupt with code n redirects to base + 4*n. Exceptions still redirect to the base.
- R7: Interrupt n is taken only when `irq_pend[n]`, `irq_en[n]` and `irq_gie` are all 1. Any exception wins over every interrupt. Among interrupts, the lowest index wins.
- R8: A machine return (`ret_is_m`=1) is legal only in machine mode. A supervisor return is legal in supervisor or machine mode. A legal return with no trap in the same cycle redirects to the exception-PC register, restores the saved mode into the current mode, and sets the saved mode to user.
- R9: An illegal return raises exception code 2 instead of returning. This follows all the rules of R2 to R5.
- R10: CSR select 0 is the vector, 1 the exception PC, 2 the cause, and 3 the status. Status bits [1:0] are the current mode and bits [3:2] the saved mode. Only the saved mode can be written through status, and a written 2 is stored as 0. Reads are combinational. A trap in the same cycle wins over a CSR write to the exception PC or the cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 16 | One request line per exception code |
| exc_pc | input | XLEN | PC of the instruction being retired or interrupted |
| irq_pend | input | NIRQ | Interrupt pending lines, index = code |
| irq_en | input | NIRQ | Per-interrupt enables |
| irq_gie | input | 1 | Global interrupt enable |
| ret_valid | input | 1 | A privileged return is retiring |
| ret_is_m | input | 1 | 1 = machine return, 0 = supervisor return |
| csr_we | input | 1 | CSR write strobe |
| csr_sel | input | 2 | Trap register select |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data |
| redirect_valid | output | 1 | Fetch must redirect this cycle |
| redirect_pc | output | XLEN | Redirect target |
| cur_mode | output | 2 | Current privilege mode |

## Verification
A wrong priority or a wrong vector offset shows up at `redirect_pc` in the same cycle as the stimulus. A wrong cause or a wrong saved PC becomes readable on the CSR port one edge later. A wrong saved mode stays hidden until the next return: it then appears at `cur_mode` one edge after the return strobe, or as an unexpected illegal-instruction trap. For that reason the return sequences are run as chains that move through all three modes.

// File: rtl/trap_ctrl.sv
module trap_ctrl #(
  parameter int XLEN = 32,
  parameter int NIRQ = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [15:0]     exc_req,
  input  logic [XLEN-1:0] exc_pc,
  input  logic [NIRQ-1:0] irq_pend,
  input  logic [NIRQ-1:0] irq_en,
  input  logic            irq_gie,
  input  logic            ret_valid,
  input  logic            ret_is_m,
  input  logic            csr_we,
  input  logic [1:0]      csr_sel,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc,
  output logic [1:0]      cur_mode
);
  localparam int CW = (NIRQ > 16) ? $clog2(NIRQ) : 4;
  localparam logic [15:0] EXC_KNOWN = 16'hB1FF;
  localparam logic [1:0] M_U = 2'd0, M_S = 2'd1, M_M = 2'd3;

  logic [XLEN-1:0] vec_q, epc_q, cause_q;
  logic [1:0]      mode_q, prev_q;
  logic [CW-1:0]   exc_code, irq_code, code;
  logic [15:0]     exc_all;
  logic [NIRQ-1:0] irq_live;
  logic            ret_bad, take_exc, take_irq, trap, ret_ok;
  logic [XLEN-1:0] base;

  assign ret_bad  = ret_valid & (ret_is_m ? (mode_q != M_M) : (mode_q == M_U));
  assign exc_all  = (exc_req & EXC_KNOWN) | {13'b0, ret_bad, 2'b0};
  assign irq_live = irq_pend & irq_en & {NIRQ{irq_gie}};

  always_comb begin
    exc_code = '0;
    irq_code = '0;
    for (int i = 15; i >= 0; i--)
      if (exc_all[i]) exc_code = CW'(i);
    for (int j = NIRQ - 1; j >= 0; j--)
      if (irq_live[j]) irq_code = CW'(j);
  end

  assign take_exc = |exc_all;
  assign take_irq = !take_exc && (|irq_live);
  assign trap     = take_exc | take_irq;
  assign code     = take_exc ? exc_code : irq_code;
  assign ret_ok   = ret_valid & !ret_bad & !trap;
  assign base     = {vec_q[XLEN-1:2], 2'b00};

  assign redirect_valid = trap | ret_ok;
  assign redirect_pc    = !trap ? epc_q :
                          (vec_q[1:0] == 2'b01 && take_irq)
                            ? base + {{(XLEN-CW-2){1'b0}}, code, 2'b00} : base;
  assign cur_mode = mode_q;

  always_comb begin
    case (csr_sel)
      2'd0:    csr_rdata = vec_q;
      2'd1:    csr_rdata = epc_q;
      2'd2:    csr_rdata = cause_q;
      default: csr_rdata = {{(XLEN-4){1'b0}}, prev_q, mode_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q   <= '0;
      epc_q   <= '0;
      cause_q <= '0;
      mode_q  <= M_M;
      prev_q  <= M_U;
    end else begin
      if (csr_we) begin
        case (csr_sel)
          2'd0:    vec_q   <= csr_wdata;
          2'd1:    epc_q   <= csr_wdata;
          2'd2:    cause_q <= csr_wdata;
          default: prev_q  <= (csr_wdata[3:2] == 2'b10) ? M_U : csr_wdata[3:2];
        endcase
      end
      if (trap) begin
        epc_q   <= exc_pc;
        cause_q <= {take_irq, {(XLEN-1-CW){1'b0}}, code};
        prev_q  <= mode_q;
        mode_q  <= M_M;
      end else if (ret_ok) begin
        mode_q <= prev_q;
        prev_q <= M_U;
      end
    end
  end

  p_mode_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != 2'b10);
  p_trap_enters_m_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> (mode_q == M_M) && (prev_q == $past(mode_q)) && (epc_q == $past(exc_pc)));
  p_cause_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> cause_q[XLEN-1] == ($past(exc_req & EXC_KNOWN) == 16'b0 && !$past(ret_bad)));
  p_direct_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trap && vec_q[1:0] != 2'b01) |-> redirect_pc == {vec_q[XLEN-1:2], 2'b00});
  p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_gie && exc_req == 16'b0 && !ret_valid) |-> !redirect_valid);
  p_mret_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_is_m && mode_q == M_M && exc_req == 16'b0 && irq_live == '0)
      |=> mode_q == $past(prev_q));
  p_bad_mret_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_is_m && mode_q != M_M && exc_req[1:0] == 2'b00)
      |=> (cause_q == XLEN'(2)) && (mode_q == M_M));
endmodule

// File: tb/trap_ctrl_tb_top.sv
module trap_ctrl_tb_top;
  logic        clk = 0, rst_n = 0;
  logic [15:0] exc_req = '0;
  logic [31:0] exc_pc = '0;
  logic [11:0] irq_pend = '0, irq_en = '0;
  logic        irq_gie = 0, ret_valid = 0, ret_is_m = 0, csr_we = 0;
  logic [1:0]  csr_sel = '0;
  logic [31:0] csr_wdata = '0, csr_rdata, redirect_pc;
  logic        redirect_valid;
  logic [1:0]  cur_mode;
  int nchk = 0, nfail = 0;

  trap_ctrl dut_i (.clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_pc(exc_pc),
    .irq_pend(irq_pend), .irq_en(irq_en), .irq_gie(irq_gie), .ret_valid(ret_valid),
    .ret_is_m(ret_is_m), .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .cur_mode(cur_mode));

  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    exc_req = '0; irq_pend = '0; irq_en = '0; irq_gie = 0;
    ret_valid = 0; ret_is_m = 0; csr_we = 0;
  endtask

  task automatic csr_wr(input logic [1:0] s, input logic [31:0] v);
    csr_sel = s; csr_wdata = v; csr_we = 1; step(); csr_we = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    csr_sel = s; #1; v = csr_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1", "mode", {30'b0, cur_mode}, 32'd3);
    chk("R1", "redirect", {31'b0, redirect_valid}, 0);
    rd(2'd0, v); chk("R1", "vec", v, 0);
    rd(2'd1, v); chk("R1", "epc", v, 0);
    rd(2'd2, v); chk("R1", "cause", v, 0);
    rd(2'd3, v); chk("R1", "status", v, 32'h3);
  endtask

  task automatic t_exc_prio();
    logic [31:0] v;
    csr_wr(2'd0, 32'h1000);
    exc_req = 16'h2220; exc_pc = 32'h200; #1;
    chk("R3", "redirect_valid", {31'b0, redirect_valid}, 1);
    chk("R5", "direct target", redirect_pc, 32'h1000);
    step(); idle();
    rd(2'd2, v); chk("R2", "lowest code wins", v, 32'd5);
    rd(2'd1, v); chk("R3", "epc saved", v, 32'h200);
    rd(2'd3, v); chk("R3", "status after trap", v, 32'hF);
    exc_req = 16'h4E00; exc_pc = 32'h999; #1;
    chk("R2", "unknown codes ignored", {31'b0, redirect_valid}, 0);
    step(); idle();
    rd(2'd2, v); chk("R2", "cause unchanged", v, 32'd5);
    rd(2'd1, v); chk("R2", "epc unchanged", v, 32'h200);
  endtask

  task automatic t_vectored();
    logic [31:0] v;
    csr_wr(2'd0, 32'h1001);
    rd(2'd0, v); chk("R10", "vec readback", v, 32'h1001);
    irq_pend = 12'h080; irq_en = 12'h080; irq_gie = 1; exc_pc = 32'h300; #1;
    chk("R6", "irq 7 vectored", redirect_pc, 32'h101C);
    step(); idle();
    rd(2'd2, v); chk("R4", "irq cause", v, 32'h8000_0007);
    exc_req = 16'h0100; #1;
    chk("R6", "exception in vectored mode", redirect_pc, 32'h1000);
    step(); idle();
    rd(2'd2, v); chk("R4", "exception cause", v, 32'd8);
    csr_wr(2'd0, 32'h1003);
    irq_pend = 12'h008; irq_en = 12'h008; irq_gie = 1; #1;
    chk("R5", "mode 11 is direct", redirect_pc, 32'h1000);
    step(); idle();
  endtask

  task automatic t_irq_gate();
    logic [31:0] v;
    csr_wr(2'd0, 32'h2001);
    irq_pend = 12'h088; irq_en = 12'h088; irq_gie = 0; #1;
    chk("R7", "gie clear blocks", {31'b0, redirect_valid}, 0);
    irq_gie = 1; irq_en = 12'h000; #1;
    chk("R7", "enable clear blocks", {31'b0, redirect_valid}, 0);
    irq_en = 12'h088; #1;
    chk("R7", "lowest irq", redirect_pc, 32'h200C);
    exc_req = 16'h0002; #1;
    chk("R7", "exception beats irq", redirect_pc, 32'h2000);
    step(); idle();
    rd(2'd2, v); chk("R7", "exception cause kept", v, 32'd1);
  endtask

  task automatic t_returns();
    logic [31:0] v;
    csr_wr(2'd0, 32'h1000);
    csr_wr(2'd3, 32'h4);
    csr_wr(2'd1, 32'h300);
    ret_valid = 1; ret_is_m = 1; #1;
    chk("R8", "mret target", redirect_pc, 32'h300);
    step(); idle();
    rd(2'd3, v); chk("R8", "mret to S", v, 32'h1);
    ret_valid = 1; ret_is_m = 1; exc_pc = 32'h444; #1;
    chk("R9", "mret in S traps", redirect_pc, 32'h1000);
    step(); idle();
    rd(2'd2, v); chk("R9", "illegal cause", v, 32'd2);
    rd(2'd3, v); chk("R9", "status after illegal", v, 32'h7);
    rd(2'd1, v); chk("R9", "epc of illegal", v, 32'h444);
    csr_wr(2'd1, 32'h500);
    ret_valid = 1; ret_is_m = 0; #1;
    chk("R8", "sret from M target", redirect_pc, 32'h500);
    step(); idle();
    rd(2'd3, v); chk("R8", "sret from M", v, 32'h1);
    csr_wr(2'd1, 32'h600);
    ret_valid = 1; ret_is_m = 0; #1;
    chk("R8", "sret from S target", redirect_pc, 32'h600);
    step(); idle();
    chk("R8", "sret to U", {30'b0, cur_mode}, 0);
    ret_valid = 1; ret_is_m = 0; exc_pc = 32'h700; #1;
    chk("R9", "sret in U traps", redirect_pc, 32'h1000);
    step(); idle();
    rd(2'd2, v); chk("R9", "sret illegal cause", v, 32'd2);
    rd(2'd3, v); chk("R9", "U saved", v, 32'h3);
  endtask

  task automatic t_csr_collide();
    logic [31:0] v;
    csr_wr(2'd3, 32'h8);
    rd(2'd3, v); chk("R10", "saved mode 2 stored as 0", v, 32'h3);
    exc_req = 16'h0001; exc_pc = 32'h777;
    csr_sel = 2'd1; csr_wdata = 32'hAAA; csr_we = 1;
    step(); idle();
    rd(2'd1, v); chk("R10", "trap beats epc write", v, 32'h777);
    rd(2'd2, v); chk("R10", "cause from trap", v, 32'd0);
    csr_wr(2'd2, 32'h1234);
    rd(2'd2, v); chk("R10", "cause write", v, 32'h1234);
  endtask

  initial begin
    #(20 * 100000);
    nfail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    step(); step(); rst_n = 1; step();
    t_reset();
    t_exc_prio();
    t_vectored();
    t_irq_gate();
    t_returns();
    t_csr_collide();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule